// File: doc/BRIEF.md
# Configurable Eight-Pin Port Cell Array

This block is the pin logic of a general-purpose port on a microcontroller-bus peripheral. The port can run in one of three port-wide modes. In register I/O mode each pin is driven from an output data register and enabled by a direction register. In address mode the pins present the low address byte, which is captured from the multiplexed address/data lines while the address-latch-enable strobe is high. In bus mode the pins act as the low data byte of a non-multiplexed bus: they drive data out during an internal read, and they hand the pad level to the addressed location during an internal write.

Each pin also has its own open-drain option. When it is set, the pin can only pull low, and a 1 releases the pad. Pads are modelled as three separate signals: out, output-enable and in. Software reaches the data, direction, mode and open-drain registers through a small internal register bus. The same bus has a separate window that returns the live pad levels.

Top module: `cfg_port_pins`

## Requirements
- R1: A synchronous active-high reset clears the data, direction, mode and open-drain registers and the held address byte. The port then comes up in register I/O mode with every pad output-enable low.
- R2: A write with `reg_wr` high loads `reg_wdata` on the next rising clock edge. Selector 0 loads data, 1 loads direction, 3 loads mode (bits 1:0) and 4 loads the open-drain mask. `reg_rdata` returns the selected register combinationally, and the mode read returns the 2-bit code zero-extended.
- R3: Selector 2 reads the live `pad_in` level, and a write to it changes no register. Selectors 5 to 7 read as zero, and writes to them are ignored.
- R4: In register I/O mode (mode code 0), a pin that is not open-drain drives `pad_out` from its data bit and `pad_oe` from its direction bit, where 1 means output.
- R5: In address mode (mode code 1), all pins are enabled and `pad_out` shows `ad_in` while `ale` is high. While `ale` is low, `pad_out` shows the `ad_in` value sampled at the last rising clock edge at which `ale` was high.
- R6: In bus mode (mode code 2), `pad_out` carries `bus_din`. All output-enables are high while `bus_rd` is high and low otherwise.
- R7: `bus_dout` always equals `pad_in`, so that during an internal write the addressed location takes the pad level.
- R8: On a pin whose open-drain bit is 1, `pad_out` is 0. Its `pad_oe` is high only when the mode would drive that pin and the value to be driven is 0.
- R9: Mode code 3 behaves exactly as register I/O mode, but it still reads back as 3.
- R10: The address byte is captured on every rising clock edge with `ale` high, whatever the mode. A register write and an address capture in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register bus selector |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ale | input | 1 | Address latch enable |
| ad_in | input | 8 | Low address bits from the multiplexed bus |
| bus_rd | input | 1 | Internal read in progress (bus mode) |
| bus_din | input | 8 | Data from the addressed internal location |
| bus_dout | output | 8 | Pad level passed to the addressed location |
| pad_in | input | 8 | Live pad levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The two functions that can land in the same cycle are a register-bus write to the data register and an address capture with `ale` high. The bench raises `reg_wr` for selector 0 and `ale` together in one clock while the port is in register I/O mode. It then checks three results separately: the data readback, the I/O-mode pad value and, once the port is switched to address mode, the held address byte. The bench also gives open-drain pins all three pin sources and compares each result against values worked out by hand.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

    typedef enum logic [1:0] {
        PM_REGIO = 2'd0,
        PM_ADDR  = 2'd1,
        PM_BUS   = 2'd2,
        PM_ALT   = 2'd3
    } port_mode_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] OFS_DATA = 3'd0;
    localparam logic [SEL_W-1:0] OFS_DIR  = 3'd1;
    localparam logic [SEL_W-1:0] OFS_PIN  = 3'd2;
    localparam logic [SEL_W-1:0] OFS_MODE = 3'd3;
    localparam logic [SEL_W-1:0] OFS_ODN  = 3'd4;

    typedef struct packed {
        logic val;
        logic en;
    } drive_t;

    // Fold the reserved code onto plain register I/O.
    function automatic port_mode_e norm_mode(logic [1:0] code);
        port_mode_e m;
        m = port_mode_e'(code);
        if (m == PM_ALT) m = PM_REGIO;
        return m;
    endfunction

    // Open-drain pins only ever pull low; a 1 releases the pad.
    function automatic drive_t apply_od(drive_t raw, logic od);
        drive_t r;
        if (od) begin
            r.val = 1'b0;
            r.en  = raw.en & ~raw.val;
        end else begin
            r = raw;
        end
        return r;
    endfunction

endpackage

// File: rtl/cpp_regfile.sv
module cpp_regfile
    import cpp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic [W-1:0]     reg_wdata,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     reg_rdata,
    output logic [W-1:0]     data_q,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     od_q,
    output port_mode_e       mode_q
);

    localparam int MODE_PAD = W - 2;

    logic [1:0] mode_code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q      <= '0;
            dir_q       <= '0;
            od_q        <= '0;
            mode_code_q <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                OFS_DATA: data_q      <= reg_wdata;
                OFS_DIR:  dir_q       <= reg_wdata;
                OFS_MODE: mode_code_q <= reg_wdata[1:0];
                OFS_ODN:  od_q        <= reg_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (reg_sel)
            OFS_DATA: reg_rdata = data_q;
            OFS_DIR:  reg_rdata = dir_q;
            OFS_PIN:  reg_rdata = pad_in;
            OFS_MODE: reg_rdata = {{MODE_PAD{1'b0}}, mode_code_q};
            OFS_ODN:  reg_rdata = od_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign mode_q = norm_mode(mode_code_q);

endmodule

// File: rtl/cpp_addr_hold.sv
module cpp_addr_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ale,
    input  logic [W-1:0] ad_in,
    output logic [W-1:0] addr_out
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)      held_q <= '0;
        else if (ale) held_q <= ad_in;
    end

    // Transparent while the strobe is high, holding once it drops.
    assign addr_out = ale ? ad_in : held_q;

endmodule

// File: rtl/cpp_pin_drive.sv
module cpp_pin_drive
    import cpp_pkg::*;
(
    input  port_mode_e mode,
    input  logic       data_bit,
    input  logic       dir_bit,
    input  logic       addr_bit,
    input  logic       bus_bit,
    input  logic       bus_rd,
    input  logic       od_bit,
    output logic       pin_out,
    output logic       pin_oe
);

    drive_t raw;
    drive_t fin;

    always_comb begin
        case (mode)
            PM_ADDR: begin
                raw.val = addr_bit;
                raw.en  = 1'b1;
            end
            PM_BUS: begin
                raw.val = bus_bit;
                raw.en  = bus_rd;
            end
            default: begin
                raw.val = data_bit;
                raw.en  = dir_bit;
            end
        endcase
        fin = apply_od(raw, od_bit);
    end

    assign pin_out = fin.val;
    assign pin_oe  = fin.en;

endmodule

// File: rtl/cfg_port_pins.sv
module cfg_port_pins
    import cpp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    input  logic             ale,
    input  logic [W-1:0]     ad_in,
    input  logic             bus_rd,
    input  logic [W-1:0]     bus_din,
    output logic [W-1:0]     bus_dout,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_oe
);

    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] od_q;
    logic [W-1:0] addr_byte;
    port_mode_e   mode_q;

    cpp_regfile #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .pad_in    (pad_in),
        .reg_rdata (reg_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .od_q      (od_q),
        .mode_q    (mode_q)
    );

    cpp_addr_hold #(.W(W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .ale      (ale),
        .ad_in    (ad_in),
        .addr_out (addr_byte)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        cpp_pin_drive u_pin (
            .mode     (mode_q),
            .data_bit (data_q[i]),
            .dir_bit  (dir_q[i]),
            .addr_bit (addr_byte[i]),
            .bus_bit  (bus_din[i]),
            .bus_rd   (bus_rd),
            .od_bit   (od_q[i]),
            .pin_out  (pad_out[i]),
            .pin_oe   (pad_oe[i])
        );
    end

    assign bus_dout = pad_in;

endmodule

// File: rtl/cfg_port_pins_chk.sv
module cfg_port_pins_chk
    import cpp_pkg::*;
#(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] reg_sel,
    input logic             reg_wr,
    input logic [W-1:0]     reg_wdata,
    input logic             ale,
    input logic             bus_rd,
    input logic [W-1:0]     pad_out,
    input logic [W-1:0]     pad_oe,
    input logic [W-1:0]     data_q,
    input logic [W-1:0]     dir_q,
    input logic [W-1:0]     od_q,
    input port_mode_e       mode_q
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && data_q == '0 && mode_q == PM_REGIO));

    // R2
    data_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == OFS_DATA) |=> (data_q == $past(reg_wdata)));

    // R4
    regio_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_REGIO) |-> ((pad_oe & ~od_q) == (dir_q & ~od_q)));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_ADDR && !ale && !$past(ale) && $stable(od_q) && $stable(mode_q))
            |-> $stable(pad_out));

    // R6
    bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_BUS && !bus_rd) |-> (pad_oe == '0));

    // R8
    od_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_out & od_q) == '0);

endmodule

bind cfg_port_pins cfg_port_pins_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .ale       (ale),
    .bus_rd    (bus_rd),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .od_q      (od_q),
    .mode_q    (mode_q)
);

// File: tb/cfg_port_pins_bench.sv
`timescale 1ns/1ps
module cfg_port_pins_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_sel = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ale = 1'b0;
    logic [7:0] ad_in = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cfg_port_pins u_cfg_port_pins (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ale(ale), .ad_in(ad_in),
        .bus_rd(bus_rd), .bus_din(bus_din), .bus_dout(bus_dout),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] data;
        logic [7:0] dir;
        logic [7:0] od;
        logic       al;
        logic [7:0] ad;
        logic       brd;
        logic [7:0] bdin;
        logic [7:0] eout;
        logic [7:0] eoe;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'hA5, 8'hF0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 8'hA5, 8'hF0},
        '{2'd0, 8'h3C, 8'hFF, 8'h0F, 1'b0, 8'h00, 1'b0, 8'h00, 8'h30, 8'hF3},
        '{2'd1, 8'h00, 8'h00, 8'h00, 1'b1, 8'h96, 1'b0, 8'h00, 8'h96, 8'hFF},
        '{2'd1, 8'h00, 8'h00, 8'hF0, 1'b1, 8'h96, 1'b0, 8'h00, 8'h06, 8'h6F},
        '{2'd2, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 8'h5A, 8'h5A, 8'hFF},
        '{2'd2, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h5A, 8'h5A, 8'h00},
        '{2'd3, 8'h81, 8'h0F, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 8'h81, 8'h0F},
        '{2'd2, 8'h00, 8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 8'h00, 8'h00, 8'hFF},
        '{2'd0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] val);
        reg_sel   = sel;
        reg_wdata = val;
        reg_wr    = 1'b1;
        @(posedge clk); #1;
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] val);
        reg_sel = sel;
        #0.5;
        val = reg_rdata;
    endtask

    function automatic string tag_of(vec_t v);
        string s;
        case (v.mode)
            2'd1:    s = "R5";
            2'd2:    s = "R6";
            2'd3:    s = "R9";
            default: s = "R4";
        endcase
        if (v.od != 8'h00) s = {s, " R8"};
        return s;
    endfunction

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); check("R1 data", v, 8'h00);
        rd(3'd1, v); check("R1 dir", v, 8'h00);
        rd(3'd3, v); check("R1 mode", v, 8'h00);
        rd(3'd4, v); check("R1 od", v, 8'h00);
        check("R1 oe", pad_oe, 8'h00);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            wr(3'd3, {6'd0, VECS[k].mode});
            wr(3'd0, VECS[k].data);
            wr(3'd1, VECS[k].dir);
            wr(3'd4, VECS[k].od);
            ale     = VECS[k].al;
            ad_in   = VECS[k].ad;
            bus_rd  = VECS[k].brd;
            bus_din = VECS[k].bdin;
            #0.5;
            check({tag_of(VECS[k]), " out"}, pad_out, VECS[k].eout);
            check({tag_of(VECS[k]), " oe"}, pad_oe, VECS[k].eoe);
            @(posedge clk); #1;
            ale = 1'b0;
            bus_rd = 1'b0;
        end

        // R2 / R9 readback
        wr(3'd3, 8'h03);
        rd(3'd3, v); check("R9 mode readback", v, 8'h03);
        wr(3'd1, 8'h5C);
        rd(3'd1, v); check("R2 dir readback", v, 8'h5C);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'hE7);
        rd(3'd0, v); check("R2 data readback", v, 8'hE7);
        rd(3'd4, v); check("R2 od readback", v, 8'h00);

        // R3 pin window and empty selectors
        pad_in = 8'hC3;
        rd(3'd2, v); check("R3 pin read", v, 8'hC3);
        wr(3'd2, 8'h55);
        wr(3'd5, 8'h55);
        wr(3'd7, 8'h55);
        rd(3'd0, v); check("R3 data untouched", v, 8'hE7);
        rd(3'd1, v); check("R3 dir untouched", v, 8'h5C);
        rd(3'd4, v); check("R3 od untouched", v, 8'h00);
        rd(3'd3, v); check("R3 mode untouched", v, 8'h03);
        rd(3'd5, v); check("R3 sel5 zero", v, 8'h00);
        rd(3'd6, v); check("R3 sel6 zero", v, 8'h00);

        // R7 bus write capture path
        pad_in = 8'hA6;
        #0.5;
        check("R7 bus_dout", bus_dout, 8'hA6);

        // R5 hold after strobe drops
        wr(3'd3, 8'h01);
        ale = 1'b1; ad_in = 8'h7E;
        @(posedge clk); #1;
        ale = 1'b0; ad_in = 8'h11;
        #0.5;
        check("R5 held", pad_out, 8'h7E);
        @(posedge clk); #1;
        check("R5 still held", pad_out, 8'h7E);

        // R10 register write and address capture in one cycle
        wr(3'd3, 8'h00);
        wr(3'd1, 8'hFF);
        ale = 1'b1; ad_in = 8'h99;
        wr(3'd0, 8'h42);
        ale = 1'b0; ad_in = 8'h00;
        rd(3'd0, v); check("R10 data written", v, 8'h42);
        check("R10 io pins", pad_out, 8'h42);
        wr(3'd3, 8'h01);
        check("R10 address captured", pad_out, 8'h99);

        // R1 mid-run reset
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        rd(3'd0, v); check("R1 data after reset", v, 8'h00);
        rd(3'd3, v); check("R1 mode after reset", v, 8'h00);
        check("R1 oe after reset", pad_oe, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule